// File: doc/BRIEF.md
# Watchdog Overflow Reset Sequencer

This block converts a watchdog counter overflow into a controlled internal reset request for the processor. A reset-enable control chooses the effect of an overflow. When it is set, the overflow starts a reset. When it is clear, the overflow only clears the watchdog's own count and status through a one-cycle clear pulse. That clear pulse is produced on every overflow in either case.

Two reset types are supported. A power-on type reset is issued at once. A manual type reset opens a fixed window of `WIN_LEN` cycles (512 by default). During the window the reset is held until the bus is idle and owned by the processor. This keeps a bus transfer that is in progress intact, and it defers the reset while another master holds the bus. If that condition does not appear before the window ends, the request is discarded and no reset is taken. While a reset is pending, further overflows are ignored.

Top module: `wdt_reset_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block returns to idle: `rst_req_o`, `rst_taken_o` and `wdt_clr_o` are 0 after that edge.
- R2: `wdt_clr_o` is 1 for exactly the cycle after each edge at which `ovf_i` is sampled 1, whatever the value of `rst_en_i` and whatever the sequencer state.
- R3: An overflow with `rst_en_i` = 0 never raises `rst_req_o` or `rst_taken_o`.
- R4: From idle, an overflow with `rst_en_i` = 1 and `manual_sel_i` = 0 (power-on type) makes `rst_req_o` and `rst_taken_o` 1 in the cycle after the overflow edge, whatever the bus inputs are.
- R5: From idle, an overflow with `rst_en_i` = 1 and `manual_sel_i` = 1 (manual type) raises `rst_req_o` in the next cycle and opens the window. `rst_taken_o` is 1 in the cycle after the first window edge at which `bus_busy_i` = 0 and `bus_cpu_i` = 1.
- R6: During the window, `rst_taken_o` stays 0 while `bus_busy_i` = 1 or `bus_cpu_i` = 0, and `rst_req_o` stays 1.
- R7: If the grant condition is not met at any of the `WIN_LEN` window edges, `rst_req_o` falls after the last of them and no `rst_taken_o` pulse occurs.
- R8: A grant seen at the last (`WIN_LEN`-th) window edge still produces `rst_taken_o`.
- R9: An overflow that arrives while a reset is pending does not restart the window. The window still ends `WIN_LEN` edges after the first overflow.
- R10: `rst_taken_o` lasts exactly one cycle. After it, `rst_req_o` is 0 and a new overflow is accepted.
- R11: A synchronous reset in the middle of a window cancels it. The next overflow gets a full window of `WIN_LEN` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_i | input | 1 | Watchdog counter overflow, one-cycle pulse |
| rst_en_i | input | 1 | 1: overflow resets the chip; 0: overflow only clears the watchdog |
| manual_sel_i | input | 1 | Reset type: 1 manual (bus-gated), 0 power-on (immediate) |
| bus_busy_i | input | 1 | 1 while a bus cycle is in progress |
| bus_cpu_i | input | 1 | 1 while the processor owns the bus |
| rst_req_o | output | 1 | Internal reset request, high while a reset is pending or being issued |
| rst_taken_o | output | 1 | One-cycle pulse when the reset is issued to the processor |
| wdt_clr_o | output | 1 | One-cycle clear of the watchdog count and status |

## Verification
Every output is registered. `wdt_clr_o` and the rising `rst_req_o` are due one cycle after the overflow edge, and a power-on `rst_taken_o` is due at the same time. A manual `rst_taken_o` is due one cycle after the first window edge that sees the grant. A dropped request falls exactly `WIN_LEN` edges after the window opens. The bench drives and samples on falling edges and counts the rising edges between stimulus and check. The window tests place the grant, or its absence, at the last permitted edge and one edge later.

// File: rtl/wrs_pkg.sv
// Package: shared types of the watchdog overflow reset sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package wrs_pkg;

    // Sequencer states: idle, manual-reset wait window, one-cycle issue.
    typedef enum logic [1:0] {
        WRS_IDLE   = 2'd0,
        WRS_WINDOW = 2'd1,
        WRS_ISSUE  = 2'd2
    } wrs_state_t;

endpackage

// File: rtl/wrs_window_cnt.sv
// Module: window counter for a pending manual reset.
// Counts the cycles spent waiting for the bus and flags the last one.
// Assumes: clr has priority over en; the count never exceeds WIN_LEN-1
// because the controller leaves the window at the last count.
module wrs_window_cnt #(
    parameter int WIN_LEN = 512,
    localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);

    logic [CW-1:0] cnt_q;

    // Purpose: hold the window position; cleared outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: mark the final permitted waiting cycle.
    always_comb begin
        last = (cnt_q == CW'(WIN_LEN - 1));
    end

endmodule

// File: rtl/wrs_clr_gen.sv
// Module: watchdog clear pulse generator.
// Produces a one-cycle clear for the watchdog count and status on every
// overflow, independent of reset enable or sequencer state.
// Assumes: ovf_i is a single-cycle pulse from the counter.
module wrs_clr_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    output logic clr_o
);

    // Purpose: register the overflow into a clean clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_o <= 1'b0;
        end else begin
            clr_o <= ovf_i;
        end
    end

endmodule

// File: rtl/wrs_ctrl.sv
// Module: reset sequencing state machine.
// Accepts an enabled overflow only when idle. A power-on type goes straight
// to issue. A manual type waits in the window until the bus is idle and owned
// by the processor, or gives up after the last window cycle.
// Assumes: win_last comes from a counter that runs only in the window.
module wrs_ctrl
    import wrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic rst_en_i,
    input  logic manual_sel_i,
    input  logic bus_busy_i,
    input  logic bus_cpu_i,
    input  logic win_last,
    output logic in_window,
    output logic rst_req_o,
    output logic rst_taken_o
);

    wrs_state_t state_q, state_d;
    logic       grant;

    // Purpose: the manual reset may proceed only on an idle, processor-owned bus.
    always_comb begin
        grant = !bus_busy_i && bus_cpu_i;
    end

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WRS_IDLE: begin
                if (ovf_i && rst_en_i) begin
                    state_d = manual_sel_i ? WRS_WINDOW : WRS_ISSUE;
                end
            end
            WRS_WINDOW: begin
                if (grant) begin
                    state_d = WRS_ISSUE;
                end else if (win_last) begin
                    state_d = WRS_IDLE;
                end
            end
            WRS_ISSUE: begin
                state_d = WRS_IDLE;
            end
            default: begin
                state_d = WRS_IDLE;
            end
        endcase
    end

    // Purpose: state register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WRS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: decode Moore outputs from the state register.
    always_comb begin
        in_window   = (state_q == WRS_WINDOW);
        rst_req_o   = (state_q != WRS_IDLE);
        rst_taken_o = (state_q == WRS_ISSUE);
    end

endmodule

// File: rtl/wdt_reset_seq.sv
// Module: watchdog overflow reset sequencer (top).
// Turns a watchdog overflow into an internal reset request. With reset
// enable clear, it only clears the watchdog. A manual reset is held until the
// bus cycle ends and the processor owns the bus, within WIN_LEN cycles.
// Assumes: all inputs are synchronous to clk; ovf_i is a one-cycle pulse.
module wdt_reset_seq #(
    parameter int WIN_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic rst_en_i,
    input  logic manual_sel_i,
    input  logic bus_busy_i,
    input  logic bus_cpu_i,
    output logic rst_req_o,
    output logic rst_taken_o,
    output logic wdt_clr_o
);

    logic in_window;
    logic win_last;

    wrs_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovf_i        (ovf_i),
        .rst_en_i     (rst_en_i),
        .manual_sel_i (manual_sel_i),
        .bus_busy_i   (bus_busy_i),
        .bus_cpu_i    (bus_cpu_i),
        .win_last     (win_last),
        .in_window    (in_window),
        .rst_req_o    (rst_req_o),
        .rst_taken_o  (rst_taken_o)
    );

    wrs_window_cnt #(
        .WIN_LEN (WIN_LEN)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_window),
        .en    (in_window),
        .last  (win_last)
    );

    wrs_clr_gen u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf_i (ovf_i),
        .clr_o (wdt_clr_o)
    );

endmodule

// File: rtl/wrs_checker.sv
// Module: assertion checker for wdt_reset_seq, attached by bind.
// Assumes: observes only the top-level ports.
module wrs_checker #(
    parameter int WIN_LEN = 512,
    localparam int HW = $clog2(WIN_LEN + 2) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic ovf_i,
    input logic rst_en_i,
    input logic manual_sel_i,
    input logic bus_busy_i,
    input logic bus_cpu_i,
    input logic rst_req_o,
    input logic rst_taken_o,
    input logic wdt_clr_o
);

    logic [HW-1:0] held_q;

    // Purpose: count consecutive cycles with the request high.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_req_o) begin
            held_q <= '0;
        end else begin
            held_q <= held_q + 1'b1;
        end
    end

    // R1: reset clears the outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rst_req_o && !rst_taken_o && !wdt_clr_o));

    // R2: clear pulse follows each overflow
    a_r2_clr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> wdt_clr_o);

    a_r2_clr_only_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_i |=> !wdt_clr_o);

    // R3: no request without an enabled overflow
    a_r3_no_req_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_o && !(ovf_i && rst_en_i)) |=> !rst_req_o);

    // R4: power-on type issues at once
    a_r4_poweron_now: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_o && ovf_i && rst_en_i && !manual_sel_i) |=> rst_taken_o);

    // R6: no issue from the window without grant
    a_r6_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !rst_taken_o && !(!bus_busy_i && bus_cpu_i)) |=> !rst_taken_o);

    // R7: the request never outlives the window plus the issue cycle
    a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= HW'(WIN_LEN + 1));

    // R10: the taken pulse is single-cycle and ends the request
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_taken_o |=> (!rst_taken_o && !rst_req_o));

    a_r10_taken_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_taken_o |-> rst_req_o);

endmodule

bind wdt_reset_seq wrs_checker #(.WIN_LEN(WIN_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovf_i        (ovf_i),
    .rst_en_i     (rst_en_i),
    .manual_sel_i (manual_sel_i),
    .bus_busy_i   (bus_busy_i),
    .bus_cpu_i    (bus_cpu_i),
    .rst_req_o    (rst_req_o),
    .rst_taken_o  (rst_taken_o),
    .wdt_clr_o    (wdt_clr_o)
);

// File: tb/sim_wdt_reset_seq.sv
// Directed bench for wdt_reset_seq: one task per scenario.
module sim_wdt_reset_seq;

    localparam int WIN = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovf = 1'b0;
    logic rst_en = 1'b0;
    logic manual = 1'b0;
    logic busy = 1'b1;
    logic cpu = 1'b0;
    logic req, taken, clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wdt_reset_seq #(.WIN_LEN(WIN)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovf_i        (ovf),
        .rst_en_i     (rst_en),
        .manual_sel_i (manual),
        .bus_busy_i   (busy),
        .bus_cpu_i    (cpu),
        .rst_req_o    (req),
        .rst_taken_o  (taken),
        .wdt_clr_o    (clr)
    );

    always #2 clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one overflow pulse; returns after the overflow edge.
    task automatic pulse_ovf();
        ovf = 1'b1;
        step();
        ovf = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1 req", req, 1'b0);
        chk("R1 taken", taken, 1'b0);
        chk("R1 clr", clr, 1'b0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_disabled();
        rst_en = 1'b0; manual = 1'b1; busy = 1'b0; cpu = 1'b1;
        pulse_ovf();
        chk("R2 clr with enable off", clr, 1'b1);
        chk("R3 req", req, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R3 no req later", req, 1'b0);
            chk("R3 no taken", taken, 1'b0);
        end
        chk("R2 clr one cycle", clr, 1'b0);
    endtask

    task automatic t_poweron();
        rst_en = 1'b1; manual = 1'b0; busy = 1'b1; cpu = 1'b0;
        pulse_ovf();
        chk("R4 req", req, 1'b1);
        chk("R4 taken", taken, 1'b1);
        chk("R2 clr", clr, 1'b1);
        step();
        chk("R10 taken one cycle", taken, 1'b0);
        chk("R10 req low", req, 1'b0);
    endtask

    task automatic t_manual_now();
        manual = 1'b1; busy = 1'b0; cpu = 1'b1;
        pulse_ovf();
        chk("R5 req", req, 1'b1);
        chk("R5 not yet taken", taken, 1'b0);
        step();
        chk("R5 taken", taken, 1'b1);
        step();
        chk("R10 taken ends", taken, 1'b0);
        chk("R10 req ends", req, 1'b0);
    endtask

    task automatic t_deferred();
        bit seen = 1'b0;
        manual = 1'b1; busy = 1'b1; cpu = 1'b1;
        pulse_ovf();
        for (int i = 0; i < 20; i++) begin
            step();
            if (taken) seen = 1'b1;
        end
        busy = 1'b0; cpu = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (taken) seen = 1'b1;
        end
        chk("R6 no taken while busy or bus released", seen, 1'b0);
        chk("R6 req held", req, 1'b1);
        cpu = 1'b1;
        step();
        chk("R5 taken after grant", taken, 1'b1);
        busy = 1'b1;
        step();
    endtask

    task automatic t_drop();
        bit seen = 1'b0;
        manual = 1'b1; busy = 1'b1; cpu = 1'b1;
        pulse_ovf();
        for (int i = 0; i < WIN - 1; i++) begin
            step();
            if (taken) seen = 1'b1;
        end
        chk("R7 req held to last window edge", req, 1'b1);
        step();
        chk("R7 req dropped", req, 1'b0);
        chk("R7 no taken", seen | taken, 1'b0);
        step();
        chk("R7 still idle", req | taken, 1'b0);
    endtask

    task automatic t_last();
        manual = 1'b1; busy = 1'b1; cpu = 1'b1;
        pulse_ovf();
        for (int i = 0; i < WIN - 1; i++) step();
        busy = 1'b0;
        step();
        chk("R8 grant on last window edge", taken, 1'b1);
        busy = 1'b1;
        step();
    endtask

    task automatic t_ignore();
        manual = 1'b1; busy = 1'b1; cpu = 1'b1;
        pulse_ovf();
        for (int i = 0; i < 99; i++) step();
        pulse_ovf();
        chk("R2 clr during window", clr, 1'b1);
        for (int i = 0; i < WIN - 101; i++) step();
        chk("R9 req held", req, 1'b1);
        step();
        chk("R9 window not restarted", req, 1'b0);
        step();
    endtask

    task automatic t_sync_reset();
        manual = 1'b1; busy = 1'b1; cpu = 1'b1;
        pulse_ovf();
        for (int i = 0; i < 50; i++) step();
        rst_n = 1'b0;
        step();
        chk("R11 reset cancels window", req, 1'b0);
        chk("R1 reset clears taken", taken, 1'b0);
        rst_n = 1'b1;
        step();
        pulse_ovf();
        for (int i = 0; i < WIN - 1; i++) step();
        chk("R11 full window after reset", req, 1'b1);
        step();
        chk("R11 window ends on time", req, 1'b0);
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        step();
        t_reset();
        t_disabled();
        t_poweron();
        t_manual_now();
        t_deferred();
        t_drop();
        t_last();
        t_ignore();
        t_sync_reset();
        t_poweron();
        finish_sim();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_sim();
    end

endmodule